// File: doc/BRIEF.md
# Four-Slot Pulse-Position Infrared Frame Receiver

This block turns a recovered serial chip stream from a fast infrared link into framed receive bytes. It watches the stream for a synchronisation preamble followed by a start flag. After that it reads the stream as four-chip pulse-position symbols, and each symbol carries two bits. Every four valid symbols make one byte.

Each decoded byte is held back in a four-byte delay line, so the four bytes that arrive last are never released. When a frame ends, those four bytes are the frame check sequence. They are compared against a CRC-32 that the block computes over the bytes that did leave the delay line. The block writes bytes to a downstream receive FIFO through a write strobe. Two sideband tags travel with each byte: one marks the end of a frame and one marks a CRC mismatch. A one-cycle pulse reports each aborted frame. Chip clock recovery and the FIFO storage are outside this block. Dropping the enable stops reception at once.

Top module: `irrx_4ppm`

## Requirements
- R1: Data bytes are accepted only after the last 32 received chips match the 16-chip preamble `1000_0000_1010_1000` followed by the 16-chip start flag `0000_1100_0000_1100`. The earliest chip is leftmost, and the match is checked chip by chip.
- R2: After the start flag, chips group into four-chip symbols, with the first chip leftmost. Symbol `1000` decodes to 00, `0100` to 01, `0010` to 10 and `0001` to 11. The first symbol of a byte supplies bits [1:0] and the fourth supplies bits [7:6].
- R3: The four most recently decoded bytes are always withheld. A byte reaches `wr_data` only after four newer bytes have been decoded. Bytes leave in arrival order, and the four trailing check bytes are never written.
- R4: The stop flag is symbol `0000` followed by `1100`, starting on a byte boundary. On a valid stop, the last payload byte is written on the clock of the final stop chip with `wr_eof`=1. Every earlier byte of the frame is written with `wr_eof`=0.
- R5: The reflected CRC-32 (polynomial 0xEDB88320, preset all ones) runs over the written payload bytes. At the stop flag, its complement is compared with the four withheld bytes, taken least significant byte first. On a mismatch, `wr_crc_err`=1 is set on the end-of-frame write, and `wr_crc_err` is never set without `wr_eof`.
- R6: Inside a frame, any symbol that is not one-hot and not `0000` (for example `0011`, `1010`, `1110`) aborts the frame. `frame_abort` pulses for one cycle. On that same clock, any byte already due for output is written without a tag. On the next clock, the oldest withheld byte is written with `wr_eof`=1, and the remaining withheld bytes are dropped.
- R7: A malformed stop aborts exactly as R6. This covers `0000` followed by anything other than `1100`, and `0000` followed by `1100` when the pair does not start on a byte boundary.
- R8: A stop flag that arrives before any payload byte has passed beyond the four withheld bytes is handled as an abort per R6.
- R9: After an abort or a completed frame, the receiver hunts again, and a fresh preamble plus start flag is needed before any further byte is accepted.
- R10: While `en` is low, `rx_flush` is high, all frame state is cleared, and no write or abort is issued on the next clock.
- R11: `wr_eof` and `wr_crc_err` are only ever high together with `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; low clears all state |
| chip_valid | input | 1 | Qualifies `chip` for one clock |
| chip | input | 1 | Received chip value |
| rx_flush | output | 1 | Requests clearing of the downstream FIFO while disabled |
| wr_en | output | 1 | Write strobe to the receive FIFO |
| wr_data | output | 8 | Byte written |
| wr_eof | output | 1 | Marks the written byte as last of its frame |
| wr_crc_err | output | 1 | Marks a frame whose check sequence mismatched |
| frame_abort | output | 1 | One-cycle pulse per aborted frame |

## Verification
The bench targets the delay-line boundaries: a frame cut off with only two bytes decoded, a stop flag arriving with only four bytes held, and an abort while both the output stage and the delay line are full. A design with the wrong delay depth would leak check bytes or lose payload bytes. One that mishandled the abort would drop the untagged byte or tag the wrong one. The bench checks that no bytes leak when the preamble is missing, that a stop flag one symbol off the byte boundary is rejected, and that a corrupted check byte raises the error tag only on the final write. It also checks that dropping the enable mid-frame leaves nothing behind that a later frame could inherit.

// File: rtl/irrx_4ppm.sv
module irrx_4ppm #(
  parameter logic [15:0] PREAMBLE   = 16'b1000_0000_1010_1000,
  parameter logic [15:0] START_FLAG = 16'b0000_1100_0000_1100,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       chip_valid,
  input  logic       chip,
  output logic       rx_flush,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       wr_eof,
  output logic       wr_crc_err,
  output logic       frame_abort
);
  localparam int SYNC_W = 32;
  localparam int HOLD   = 4;

  typedef enum logic [1:0] {HUNT, DATA, STOPW} st_t;

  st_t               state;
  logic [SYNC_W-1:0] hist;
  logic [2:0]        sh;
  logic [1:0]        cc, pi;
  logic [7:0]        acc, pend;
  logic [7:0]        hold [HOLD];
  logic [2:0]        cnt;
  logic              pend_v, tail;
  logic [31:0]       crc;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  logic [3:0]  nib;
  logic [1:0]  pv;
  logic [7:0]  new_byte;
  logic        full, sync_hit, is_onehot;
  logic [31:0] fcs;

  assign rx_flush  = !en;
  assign nib       = {sh, chip};
  assign is_onehot = $onehot(nib);
  assign pv        = {nib[1] | nib[0], nib[2] | nib[0]};
  assign new_byte  = {pv, acc[7:2]};
  assign full      = (cnt == 3'(HOLD));
  assign fcs       = {hold[3], hold[2], hold[1], hold[0]};
  assign sync_hit  = ({hist[SYNC_W-2:0], chip} == {PREAMBLE, START_FLAG});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HUNT; hist <= '0; cc <= '0; pi <= '0; cnt <= '0;
      pend_v <= 1'b0; tail <= 1'b0; crc <= '1;
      wr_en <= 1'b0; wr_data <= '0; wr_eof <= 1'b0; wr_crc_err <= 1'b0; frame_abort <= 1'b0;
    end else if (!en) begin
      state <= HUNT; hist <= '0; cc <= '0; pi <= '0; cnt <= '0;
      pend_v <= 1'b0; tail <= 1'b0; crc <= '1;
      wr_en <= 1'b0; wr_eof <= 1'b0; wr_crc_err <= 1'b0; frame_abort <= 1'b0;
    end else begin
      wr_en <= 1'b0; wr_eof <= 1'b0; wr_crc_err <= 1'b0; frame_abort <= 1'b0;
      if (tail) begin
        tail   <= 1'b0;
        pend_v <= 1'b0;
        if (pend_v) begin
          wr_en <= 1'b1; wr_data <= pend; wr_eof <= 1'b1;
        end
      end
      if (chip_valid) begin
        if (state == HUNT) begin
          hist <= {hist[SYNC_W-2:0], chip};
          if (sync_hit) begin
            state <= DATA; hist <= '0; cc <= '0; pi <= '0; cnt <= '0;
            pend_v <= 1'b0; crc <= '1;
          end
        end else begin
          sh <= {sh[1:0], chip};
          cc <= cc + 2'd1;
          if (cc == 2'd3) begin
            if (state == STOPW && nib == 4'b1100 && pi == 2'd0 && full && pend_v) begin
              wr_en <= 1'b1; wr_data <= pend; wr_eof <= 1'b1;
              wr_crc_err <= (~crc != fcs);
              pend_v <= 1'b0;
              state  <= HUNT;
            end else if (state == DATA && nib == 4'b0000) begin
              state <= STOPW;
            end else if (state == DATA && is_onehot) begin
              acc <= new_byte;
              pi  <= pi + 2'd1;
              if (pi == 2'd3) begin
                if (full) begin
                  for (int k = 0; k < HOLD-1; k++) hold[k] <= hold[k+1];
                  hold[HOLD-1] <= new_byte;
                  pend   <= hold[0];
                  pend_v <= 1'b1;
                  crc    <= crc_byte(crc, hold[0]);
                  if (pend_v) begin
                    wr_en <= 1'b1; wr_data <= pend;
                  end
                end else begin
                  hold[cnt[1:0]] <= new_byte;
                  cnt <= cnt + 3'd1;
                end
              end
            end else begin
              frame_abort <= 1'b1;
              state <= HUNT;
              if (pend_v) begin
                wr_en <= 1'b1; wr_data <= pend;
              end
              pend   <= hold[0];
              pend_v <= (cnt != 3'd0);
              tail   <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

module irrx_4ppm_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic wr_en,
  input logic wr_eof,
  input logic wr_crc_err,
  input logic frame_abort
);
  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!wr_en && !frame_abort));
  p_tag_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eof || wr_crc_err) |-> wr_en);
  p_crc_flag_on_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_crc_err |-> wr_eof);
  p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !frame_abort);
  p_eof_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eof |=> !wr_eof);
endmodule

bind irrx_4ppm irrx_4ppm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_eof(wr_eof),
  .wr_crc_err(wr_crc_err), .frame_abort(frame_abort)
);

// File: tb/irrx_4ppm_test.sv
module irrx_4ppm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       chip_valid = 1'b0;
  logic       chip = 1'b0;
  logic       rx_flush, wr_en, wr_eof, wr_crc_err, frame_abort;
  logic [7:0] wr_data;

  irrx_4ppm uut (
    .clk(clk), .rst_n(rst_n), .en(en), .chip_valid(chip_valid), .chip(chip),
    .rx_flush(rx_flush), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
    .wr_crc_err(wr_crc_err), .frame_abort(frame_abort)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, gap = 0;
  logic [7:0] rec_d [64];
  logic       rec_e [64];
  logic       rec_c [64];
  int         nrec = 0, nab = 0;
  logic [7:0] tx [16];

  always @(negedge clk) begin
    if (wr_en && nrec < 64) begin
      rec_d[nrec] = wr_data; rec_e[nrec] = wr_eof; rec_c[nrec] = wr_crc_err;
      nrec++;
    end
    if (frame_abort) nab++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_rec();
    nrec = 0; nab = 0;
  endtask

  task automatic send_chip(input logic b);
    @(negedge clk); chip <= b; chip_valid <= 1'b1;
    @(negedge clk); chip_valid <= 1'b0;
    gap = (gap + 1) % 3;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_sym(input logic [3:0] s);
    for (int i = 3; i >= 0; i--) send_chip(s[i]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 4; i++) send_sym(4'b1000 >> b[2*i +: 2]);
  endtask

  task automatic send_sync(input bit with_pre);
    if (with_pre) begin
      send_sym(4'b1000); send_sym(4'b0000); send_sym(4'b1010); send_sym(4'b1000);
    end
    send_sym(4'b0000); send_sym(4'b1100); send_sym(4'b0000); send_sym(4'b1100);
  endtask

  task automatic send_stop();
    send_sym(4'b0000); send_sym(4'b1100);
  endtask

  function automatic logic [31:0] model_crc(input int n);
    logic [31:0] r = '1;
    for (int j = 0; j < n; j++) begin
      r ^= {24'd0, tx[j]};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return ~r;
  endfunction

  task automatic send_frame(input int n, input bit corrupt);
    logic [31:0] f;
    f = model_crc(n);
    if (corrupt) f[12] = ~f[12];
    send_sync(1);
    for (int j = 0; j < n; j++) send_byte(tx[j]);
    for (int k = 0; k < 4; k++) send_byte(f[8*k +: 8]);
    send_stop();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_good(input int n, input bit err, input string req);
    chk(nrec == n, req, nrec, n);
    for (int j = 0; j < n && j < nrec; j++) begin
      chk(rec_d[j] == tx[j], req, rec_d[j], tx[j]);
      chk(rec_e[j] == (j == n-1), req, rec_e[j], j == n-1);
      chk(rec_c[j] == (err && j == n-1), req, rec_c[j], err && j == n-1);
    end
    chk(nab == 0, req, nab, 0);
  endtask

  task automatic t_reset();
    chk(!wr_en && !frame_abort && !wr_eof && !wr_crc_err, "R10 reset quiet", wr_en, 0);
    chk(rx_flush == 1'b0, "R10 flush low when enabled", rx_flush, 0);
  endtask

  task automatic t_good();
    clr_rec();
    tx[0]=8'hA5; tx[1]=8'h3C; tx[2]=8'h00; tx[3]=8'hFF; tx[4]=8'h1B; tx[5]=8'hE4;
    send_frame(6, 0);
    check_good(6, 0, "R2 R3 R4 R5 good frame");
  endtask

  task automatic t_badcrc();
    clr_rec();
    tx[0]=8'h12; tx[1]=8'h34; tx[2]=8'h56;
    send_frame(3, 1);
    check_good(3, 1, "R5 crc mismatch tag");
  endtask

  task automatic abort_after(input int n, input logic [3:0] s1, input logic [3:0] s2, input bit two);
    clr_rec();
    for (int j = 0; j < n; j++) tx[j] = 8'h40 + 8'(j * 7);
    send_sync(1);
    for (int j = 0; j < n; j++) send_byte(tx[j]);
    send_sym(s1);
    if (two) send_sym(s2);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_abort(input int nw, input string req);
    chk(nab == 1, req, nab, 1);
    chk(nrec == nw, req, nrec, nw);
    for (int j = 0; j < nw && j < nrec; j++) begin
      chk(rec_d[j] == tx[j], req, rec_d[j], tx[j]);
      chk(rec_e[j] == (j == nw-1) && !rec_c[j], req, rec_e[j], j == nw-1);
    end
  endtask

  task automatic t_invalid();
    abort_after(6, 4'b1010, 4'b0, 0);
    expect_abort(3, "R6 invalid symbol full line");
    abort_after(2, 4'b0011, 4'b0, 0);
    expect_abort(1, "R6 invalid symbol early");
    abort_after(6, 4'b1110, 4'b0, 0);
    expect_abort(3, "R6 invalid symbol 1110");
  endtask

  task automatic t_badstop();
    abort_after(6, 4'b0000, 4'b0100, 1);
    expect_abort(3, "R7 stop second symbol wrong");
    clr_rec();
    for (int j = 0; j < 5; j++) tx[j] = 8'h90 + 8'(j);
    send_sync(1);
    for (int j = 0; j < 5; j++) send_byte(tx[j]);
    send_sym(4'b0100);
    send_stop();
    repeat (4) @(negedge clk);
    expect_abort(2, "R7 stop off byte boundary");
  endtask

  task automatic t_short();
    clr_rec();
    for (int j = 0; j < 4; j++) tx[j] = 8'hC0 + 8'(j);
    send_sync(1);
    for (int j = 0; j < 4; j++) send_byte(tx[j]);
    send_stop();
    repeat (4) @(negedge clk);
    expect_abort(1, "R8 stop with no payload");
  endtask

  task automatic t_nopre();
    clr_rec();
    tx[0]=8'h55; tx[1]=8'hAA;
    send_sync(0);
    for (int j = 0; j < 6; j++) send_byte(8'h77);
    send_stop();
    repeat (4) @(negedge clk);
    chk(nrec == 0, "R1 no preamble no writes", nrec, 0);
    chk(nab == 0, "R1 no preamble no abort", nab, 0);
  endtask

  task automatic t_rehunt();
    abort_after(6, 4'b1010, 4'b0, 0);
    clr_rec();
    for (int j = 0; j < 6; j++) send_byte(8'h3A);
    send_stop();
    repeat (4) @(negedge clk);
    chk(nrec == 0 && nab == 0, "R9 no bytes after abort without sync", nrec, 0);
    clr_rec();
    tx[0]=8'h01; tx[1]=8'h80;
    send_frame(2, 0);
    check_good(2, 0, "R9 frame after abort");
  endtask

  task automatic t_enable();
    clr_rec();
    send_sync(1);
    for (int j = 0; j < 6; j++) send_byte(8'h66);
    @(negedge clk); en <= 1'b0;
    @(negedge clk);
    chk(rx_flush == 1'b1, "R10 flush while disabled", rx_flush, 1);
    repeat (3) @(negedge clk);
    chk(nrec == 1, "R10 only pre-disable write", nrec, 1);
    en <= 1'b1;
    clr_rec();
    for (int j = 0; j < 4; j++) send_byte(8'h66);
    send_stop();
    repeat (4) @(negedge clk);
    chk(nrec == 0 && nab == 0, "R10 state cleared by disable", nrec, 0);
    tx[0]=8'hDE; tx[1]=8'hAD; tx[2]=8'hBE; tx[3]=8'hEF; tx[4]=8'h07;
    send_frame(5, 0);
    check_good(5, 0, "R10 R11 frame after re-enable");
  endtask

  initial begin
    #(8 * 190000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    en <= 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_badcrc();
    t_invalid();
    t_badstop();
    t_short();
    t_nopre();
    t_rehunt();
    t_enable();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule